// File: doc/BRIEF.md
# Command-Processor ALU Execute Stage

This block is the arithmetic and logic stage of a small 32-bit command-processor microcontroller. Each cycle it may accept one 32-bit instruction word, together with the values already read from the register file for that instruction's source fields. One clock later it presents a destination register index, a 32-bit result and a write strobe for the register file. Fetch, the register file itself, control-register access, memory access and branching are handled by other blocks.

Two encodings are accepted. In the immediate form a register is combined with a zero-extended 16-bit constant. In the two-register form two register values are combined, and the operation is chosen by a 5-bit field in the low bits of the word. The 6-bit header in the top bits is variable length. Below 0x30 it packs a 5-bit opcode and a repeat bit. From 0x30 up it is a plain 6-bit opcode that belongs to another unit, so this stage writes nothing for it. The repeat bit is forwarded but not acted on.

A single carry/borrow flag is kept between instructions. A 64-bit add or subtract is therefore issued as a low-half instruction followed by a high-half instruction.

Top module: `cpalu_exec_top`

## Requirements
- R1: The header is insn[31:26]. When the header is below 0x30, the opcode is header[5:1] and the repeat output equals header[0]. When the header is 0x30 or above, the cycle after it is presented shows write strobe 0 and repeat 0.
- R2: Immediate form (any opcode other than 0x13): source value is src1_val, second operand is insn[15:0] zero-extended, destination is insn[20:16]. Results appear on the outputs in the cycle after in_valid is sampled high.
- R3: Opcode 0x13 selects the two-register form: the operation is insn[4:0] using the same numbering, operands are src1_val (field insn[25:21]) and src2_val (field insn[20:16]), and the destination is insn[15:11].
- R4: ADD (0x01) returns the 32-bit sum and sets the flag to the carry out. SUB (0x03) returns the 32-bit difference and sets the flag to 1 when the first operand is unsigned-less than the second.
- R5: ADDHI (0x02) adds the flag as carry-in, and SUBHI (0x04) subtracts it as borrow-in. Both update the flag the same way as R4. No other instruction or idle cycle changes the flag.
- R6: AND 0x05, OR 0x06 and XOR 0x07 are bitwise. NOT 0x08 returns the inverse of the second operand and ignores the first.
- R7: SHL 0x09, USHR 0x0a (logical), ISHR 0x0b (arithmetic) and ROT 0x0c (left rotate) shift the first operand by the low 5 bits of the second operand.
- R8: MUL8 0x0d returns the zero-extended 16-bit product of the low bytes of both operands. MIN 0x0e and MAX 0x0f compare as unsigned values.
- R9: CMP 0x10 returns 0 when the operands are equal, 1 when the first is greater, and 2 when the first is less (unsigned).
- R10: MOVI 0x11 in the immediate form writes insn[15:0] shifted left by insn[25:21]. In the two-register form it copies the second operand.
- R11: MSB 0x14 (two-register form only) returns the bit index of the highest set bit of the second operand, or 0 when it is 0. Header opcode 0x14 in the immediate form writes nothing.
- R12: NOP 0x00, any undefined operation, and any cycle without in_valid give write strobe 0 with destination and data 0 on the following cycle.
- R13: While reset is asserted, the write strobe, destination, data, repeat and flag outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid this cycle |
| insn | input | 32 | Instruction word |
| src1_val | input | 32 | Value of the register named by insn[25:21] |
| src2_val | input | 32 | Value of the register named by insn[20:16] (two-register form) |
| wr_en | output | 1 | Register write strobe |
| wr_dst | output | 5 | Destination register index |
| wr_data | output | 32 | Result value |
| rep_flag | output | 1 | Decoded repeat bit, forwarded |
| carry_flag | output | 1 | Current carry/borrow flag |

## Verification
The assertions assume that in_valid, insn and both operand values are settled, known values at every rising edge after reset, and that the operand values already match the register fields of the same word. The bench drives all inputs on the falling edge. Its reference model computes results from whatever operand values it drives, so no register-file consistency is needed. Stimulus covers headers both below and above 0x30, and both encoding forms. It also covers undefined operation fields and idle cycles.

// File: rtl/cpalu_pkg.sv
package cpalu_pkg;

  localparam int DATA_W  = 32;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;
  localparam int HDR_W   = 6;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int BYTE_W  = 8;

  typedef enum logic [4:0] {
    OP_NOP   = 5'h00,
    OP_ADD   = 5'h01,
    OP_ADDHI = 5'h02,
    OP_SUB   = 5'h03,
    OP_SUBHI = 5'h04,
    OP_AND   = 5'h05,
    OP_OR    = 5'h06,
    OP_XOR   = 5'h07,
    OP_NOT   = 5'h08,
    OP_SHL   = 5'h09,
    OP_USHR  = 5'h0a,
    OP_ISHR  = 5'h0b,
    OP_ROT   = 5'h0c,
    OP_MUL8  = 5'h0d,
    OP_MIN   = 5'h0e,
    OP_MAX   = 5'h0f,
    OP_CMP   = 5'h10,
    OP_MOVI  = 5'h11,
    OP_TWOR  = 5'h13,
    OP_MSB   = 5'h14
  } alu_op_e;

  typedef logic [DATA_W-1:0] word_t;

  function automatic word_t f_rotl(word_t v, logic [SHAMT_W-1:0] n);
    logic [SHAMT_W:0] back;
    back = (SHAMT_W+1)'(DATA_W) - {1'b0, n};
    return (v << n) | (v >> back);
  endfunction

  function automatic word_t f_msb_index(word_t v);
    logic [SHAMT_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (v[i]) idx = SHAMT_W'(i);
    end
    return word_t'(idx);
  endfunction

  function automatic word_t f_cmp3(word_t a, word_t b);
    if (a == b) return word_t'(0);
    else if (a > b) return word_t'(1);
    else return word_t'(2);
  endfunction

  function automatic word_t f_mul8(word_t a, word_t b);
    logic [2*BYTE_W-1:0] p;
    p = (2*BYTE_W)'(a[BYTE_W-1:0]) * (2*BYTE_W)'(b[BYTE_W-1:0]);
    return word_t'(p);
  endfunction

  function automatic logic f_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDHI) || (op == OP_SUB) || (op == OP_SUBHI);
  endfunction

endpackage

// File: rtl/cpalu_decode.sv
module cpalu_decode
  import cpalu_pkg::*;
(
  input  logic [DATA_W-1:0] insn,
  output alu_op_e           op,
  output logic              two_reg,
  output logic              known,
  output logic              rep,
  output logic [REG_W-1:0]  dst,
  output logic [IMM_W-1:0]  imm,
  output logic [REG_W-1:0]  movi_sh
);

  localparam logic [HDR_W-1:0] LONG_BASE = 6'h30;

  logic [HDR_W-1:0] hdr;
  logic             long_hdr;
  logic [4:0]       base_op;
  logic [4:0]       raw_op;

  assign hdr      = insn[DATA_W-1 -: HDR_W];
  assign long_hdr = (hdr >= LONG_BASE);
  assign base_op  = long_hdr ? 5'h00 : hdr[HDR_W-1:1];
  assign rep      = long_hdr ? 1'b0 : hdr[0];
  assign two_reg  = !long_hdr && (base_op == OP_TWOR);
  assign raw_op   = two_reg ? insn[4:0] : base_op;
  assign op       = alu_op_e'(raw_op);
  assign imm      = insn[IMM_W-1:0];
  assign movi_sh  = insn[25:21];
  assign dst      = two_reg ? insn[15:11] : insn[20:16];

  always_comb begin
    known = 1'b0;
    if (!long_hdr) begin
      if (raw_op >= 5'h01 && raw_op <= 5'h11) known = 1'b1;
      else if (raw_op == OP_MSB && two_reg)   known = 1'b1;
    end
  end

endmodule

// File: rtl/cpalu_datapath.sv
module cpalu_datapath
  import cpalu_pkg::*;
(
  input  alu_op_e           op,
  input  logic              two_reg,
  input  logic [DATA_W-1:0] src1_val,
  input  logic [DATA_W-1:0] src2_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [REG_W-1:0]  movi_sh,
  input  logic              flag_in,
  output logic [DATA_W-1:0] result,
  output logic              flag_out
);

  logic [DATA_W-1:0]  a, b;
  logic [DATA_W:0]    sum_ext, dif_ext;
  logic               cin;
  logic [SHAMT_W-1:0] sh;
  logic [DATA_W-1:0]  imm_ext;

  assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
  assign a   = src1_val;
  assign b   = two_reg ? src2_val : imm_ext;
  assign sh  = b[SHAMT_W-1:0];
  assign cin = ((op == OP_ADDHI) || (op == OP_SUBHI)) ? flag_in : 1'b0;

  assign sum_ext = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  assign dif_ext = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};

  always_comb begin
    result   = '0;
    flag_out = flag_in;
    unique case (op)
      OP_ADD, OP_ADDHI: begin
        result   = sum_ext[DATA_W-1:0];
        flag_out = sum_ext[DATA_W];
      end
      OP_SUB, OP_SUBHI: begin
        result   = dif_ext[DATA_W-1:0];
        flag_out = dif_ext[DATA_W];
      end
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_NOT:  result = ~b;
      OP_SHL:  result = a << sh;
      OP_USHR: result = a >> sh;
      OP_ISHR: result = $signed(a) >>> sh;
      OP_ROT:  result = f_rotl(a, sh);
      OP_MUL8: result = f_mul8(a, b);
      OP_MIN:  result = (a < b) ? a : b;
      OP_MAX:  result = (a > b) ? a : b;
      OP_CMP:  result = f_cmp3(a, b);
      OP_MOVI: result = two_reg ? b : (imm_ext << movi_sh);
      OP_MSB:  result = f_msb_index(b);
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/cpalu_flag.sv
module cpalu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic nxt,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= nxt;
  end

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flag_q));

endmodule

// File: rtl/cpalu_exec_top.sv
module cpalu_exec_top
  import cpalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] insn,
  input  logic [DATA_W-1:0] src1_val,
  input  logic [DATA_W-1:0] src2_val,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_dst,
  output logic [DATA_W-1:0] wr_data,
  output logic              rep_flag,
  output logic              carry_flag
);

  alu_op_e           dec_op;
  logic              dec_two, dec_known, dec_rep;
  logic [REG_W-1:0]  dec_dst, dec_sh;
  logic [IMM_W-1:0]  dec_imm;
  logic [DATA_W-1:0] ex_result;
  logic              ex_flag;
  logic              issue_write;
  logic              flag_upd;

  cpalu_decode u_dec (
    .insn    (insn),
    .op      (dec_op),
    .two_reg (dec_two),
    .known   (dec_known),
    .rep     (dec_rep),
    .dst     (dec_dst),
    .imm     (dec_imm),
    .movi_sh (dec_sh)
  );

  cpalu_datapath u_dp (
    .op       (dec_op),
    .two_reg  (dec_two),
    .src1_val (src1_val),
    .src2_val (src2_val),
    .imm      (dec_imm),
    .movi_sh  (dec_sh),
    .flag_in  (carry_flag),
    .result   (ex_result),
    .flag_out (ex_flag)
  );

  assign issue_write = in_valid && dec_known;
  assign flag_upd    = issue_write && f_is_arith(dec_op);

  cpalu_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (flag_upd),
    .nxt    (ex_flag),
    .flag_q (carry_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_dst   <= '0;
      wr_data  <= '0;
      rep_flag <= 1'b0;
    end else begin
      wr_en    <= issue_write;
      wr_dst   <= issue_write ? dec_dst : '0;
      wr_data  <= issue_write ? ex_result : '0;
      rep_flag <= in_valid ? dec_rep : 1'b0;
    end
  end

  // R12
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && wr_data == '0));

  // R1
  long_hdr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31:30] == 2'b11 && insn[29:28] == 2'b11) |=> (!wr_en && !rep_flag));

  // R11
  imm_msb_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn[31:27] == 5'h14) |=> !wr_en);

  // R9
  cmp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_write && dec_op == OP_CMP) |=> (wr_data <= 32'd2));

  // R8
  mul8_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_write && dec_op == OP_MUL8) |=> (wr_data[31:16] == 16'h0));

endmodule

// File: tb/cpalu_exec_top_test.sv
module cpalu_exec_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] insn, src1_val, src2_val;
  logic        wr_en, rep_flag, carry_flag;
  logic [4:0]  wr_dst;
  logic [31:0] wr_data;

  int compared = 0;
  int mismatched = 0;
  logic m_flag = 1'b0;

  always #5 clk = ~clk;

  cpalu_exec_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src1_val(src1_val), .src2_val(src2_val), .wr_en(wr_en),
    .wr_dst(wr_dst), .wr_data(wr_data), .rep_flag(rep_flag),
    .carry_flag(carry_flag)
  );

  function automatic logic [31:0] imm_w(int op, bit r, int s, int d, int im);
    return {op[4:0], r, s[4:0], d[4:0], im[15:0]};
  endfunction

  function automatic logic [31:0] rr_w(int op, bit r, int s1, int s2, int d);
    return {5'h13, r, s1[4:0], s2[4:0], d[4:0], 2'b01, 4'h0, op[4:0]};
  endfunction

  // behavioural reference: returns tag, updates m_flag
  function automatic string model(logic v, logic [31:0] w, logic [31:0] s1, logic [31:0] s2,
                                  output logic we, output logic [4:0] d,
                                  output logic [31:0] dat, output logic rp);
    logic [63:0] a, b, t;
    int hdr, op, n;
    bit two;
    string tag;
    we = 0; d = 0; dat = 0; rp = 0;
    if (!v) return "R12";
    hdr = int'(w[31:26]);
    if (hdr >= 48) return "R1";
    rp  = w[26];
    two = (hdr / 2) == 19;
    op  = two ? int'(w[4:0]) : hdr / 2;
    a   = {32'h0, s1};
    b   = two ? {32'h0, s2} : {48'h0, w[15:0]};
    n   = int'(b % 32);
    we  = 1;
    tag = "R12";
    case (op)
      1, 2: begin t = a + b + ((op == 2) ? {63'h0, m_flag} : 64'h0);
                  m_flag = t[32]; tag = (op == 1) ? "R4" : "R5"; end
      3, 4: begin t = a - b - ((op == 4) ? {63'h0, m_flag} : 64'h0);
                  m_flag = t[63]; tag = (op == 3) ? "R4" : "R5"; end
      5: begin t = a & b; tag = "R6"; end
      6: begin t = a | b; tag = "R6"; end
      7: begin t = a ^ b; tag = "R6"; end
      8: begin t = ~b; tag = "R6"; end
      9: begin t = a << n; tag = "R7"; end
      10: begin t = a >> n; tag = "R7"; end
      11: begin t = {{32{a[31]}}, a[31:0]} >> n; tag = "R7"; end
      12: begin t = (a << n) | (a >> (32 - n)); tag = "R7"; end
      13: begin t = (a % 256) * (b % 256); tag = "R8"; end
      14: begin t = (a < b) ? a : b; tag = "R8"; end
      15: begin t = (a > b) ? a : b; tag = "R8"; end
      16: begin t = (a == b) ? 0 : ((a > b) ? 1 : 2); tag = "R9"; end
      17: begin t = two ? b : ({48'h0, w[15:0]} << w[25:21]); tag = "R10"; end
      20: begin
        tag = "R11";
        if (!two) we = 0;
        else begin
          t = 0;
          for (int i = 0; i < 32; i++) if (b[i]) t = i;
        end
      end
      default: we = 0;
    endcase
    if (we) begin
      dat = t[31:0];
      d = two ? w[15:11] : w[20:16];
    end
    return tag;
  endfunction

  task automatic step(logic v, logic [31:0] w, logic [31:0] s1, logic [31:0] s2, string force_tag);
    logic ewe, erp; logic [4:0] ed; logic [31:0] ed32;
    string tag;
    in_valid = v; insn = w; src1_val = s1; src2_val = s2;
    tag = model(v, w, s1, s2, ewe, ed, ed32, erp);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    compared++;
    if (wr_en !== ewe || wr_dst !== ed || wr_data !== ed32 || rep_flag !== erp || carry_flag !== m_flag) begin
      mismatched++;
      $display("FAIL %s insn=%08h actual we=%0b dst=%0d data=%08h rep=%0b c=%0b expected we=%0b dst=%0d data=%08h rep=%0b c=%0b",
               tag, w, wr_en, wr_dst, wr_data, rep_flag, carry_flag, ewe, ed, ed32, erp, m_flag);
    end
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; insn = 0; src1_val = 0; src2_val = 0;
    repeat (3) @(negedge clk);
    compared++;
    if (wr_en !== 0 || wr_dst !== 0 || wr_data !== 0 || rep_flag !== 0 || carry_flag !== 0) begin
      mismatched++;
      $display("FAIL R13 actual we=%0b data=%08h c=%0b expected 0", wr_en, wr_data, carry_flag);
    end
    rst_n = 1;
    step(1, imm_w(1, 0, 3, 7, 16'h0001), 32'hFFFF_FFFF, 0, "R4");
    step(1, imm_w(2, 0, 4, 8, 16'h0000), 32'h0000_0010, 0, "R5");
    step(1, imm_w(3, 1, 3, 9, 16'h0005), 32'h0000_0002, 0, "R4");
    step(1, imm_w(4, 0, 4, 10, 16'h0000), 32'h0000_0001, 0, "R5");
    step(0, imm_w(1, 0, 1, 1, 16'hFFFF), 32'hFFFF_FFFF, 0, "R12");
    step(1, imm_w(0, 0, 1, 2, 16'h1234), 32'h1, 0, "R12");
    step(1, rr_w(8, 0, 5, 6, 11), 32'hDEAD_BEEF, 32'h0F0F_0000, "R6");
    step(1, rr_w(11, 0, 1, 2, 3), 32'h8000_0000, 32'h0000_0024, "R7");
    step(1, rr_w(12, 1, 1, 2, 3), 32'h8000_0001, 32'h0000_0001, "R7");
    step(1, rr_w(13, 0, 1, 2, 4), 32'h1234_56FF, 32'h0000_03FF, "R8");
    step(1, rr_w(16, 0, 1, 2, 4), 32'h5, 32'h5, "R9");
    step(1, imm_w(16, 0, 1, 2, 16'h0009), 32'h5, 0, "R9");
    step(1, imm_w(17, 0, 20, 12, 16'h00AB), 0, 0, "R10");
    step(1, rr_w(20, 0, 1, 2, 13), 0, 32'h0040_0001, "R11");
    step(1, rr_w(20, 0, 1, 2, 13), 0, 32'h0, "R11");
    step(1, imm_w(20, 0, 1, 2, 16'h0040), 32'hFF, 0, "R11");
    step(1, {6'h35, 26'h3FF_FFFF}, 32'h1, 32'h1, "R1");
    step(1, rr_w(5, 0, 1, 2, 31), 32'hF0F0_F0F0, 32'h3C3C_3C3C, "R3");
    step(1, imm_w(7, 1, 1, 30, 16'hFFFF), 32'h1234_5678, 0, "R2");
    step(1, rr_w(19, 0, 1, 2, 3), 32'h1, 32'h1, "R12");
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 3 == 0) w[31:27] = 5'h13;
      step((k % 7) != 0, w, $urandom, (k % 5 == 0) ? 32'h0 : $urandom, "");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule